// File: doc/BRIEF.md
# DMA Channel Programming Register File

This block is the host-side programming interface of a four-channel fly-by DMA controller. A host reaches it through a narrow 8-bit port. For each channel it stores a 16-bit start address, a 16-bit start count, the current address and the remaining count. Because every 16-bit value passes through one 8-bit port, a single byte-pointer flip-flop, shared by all channels, picks the low or high byte. Any access to an address or count port toggles it. A dedicated port write sends it back to the low byte.

The block also holds a mask bit for each channel and a mode nibble for each channel. The mode nibble gives the transfer direction, the transfer kind and whether autoinitialize is on. A master-clear write puts the masks, the pointer and the modes back to a safe state. The transfer engine, which lives outside this block, reports each completed unit with a step strobe. The block then advances that channel's current address and count, raises terminal count when the remaining count was already zero, and reloads the start values if autoinitialize is set.

Top module: `xfer_chan_regs`

## Requirements
- R1: Ports 0x0 to 0x7 are channel ports. port[2:1] is the channel and port[0] is 0 for address, 1 for count. The first access after the pointer is cleared reaches the low byte and the next reaches the high byte. Every read or write of a channel port toggles the shared pointer. No other port toggles it.
- R2: A write to port 0xA returns the byte pointer to the low byte. No register value changes.
- R3: A write to a channel port stores the byte into both the start value and the current value. A read returns the matching byte of the current address or the remaining count.
- R4: A step strobe for a channel adds 1 to its current address and subtracts 1 from its count. tc is high in the step cycle when the count is already 0, so a programmed count of N-1 raises tc on the Nth step.
- R5: If autoinitialize is on, the terminal-count step reloads the current address and count from the start values. If it is off, the count wraps to 0xFFFF and the address keeps incrementing.
- R6: A write to port 0x8 sets (wdata[2]=1) or clears (wdata[2]=0) the mask bit of channel wdata[1:0]. No other mask bit changes.
- R7: A write to port 0xC clears all mask bits. A write to port 0xD loads mask bit c from wdata[c].
- R8: A write to port 0x9 loads the mode of channel wdata[1:0]. The mode is presented on chan_mode[4c+3:4c] as {autoinit=wdata[5], kind=wdata[4:3], to_io=wdata[2]}. kind is 0 demand, 1 single, 2 block, 3 cascade. to_io is 1 for memory to I/O.
- R9: A write to port 0xB (master clear) sets every mask bit, clears every mode and returns the pointer to the low byte. The address and count values are kept.
- R10: After reset, all masks are 1, all modes are 0, the pointer is low and every address and count is 0.
- R11: If wr_en and rd_en are both high, only the write happens. rdata is 0 unless a channel port is being read. Ports 0xE and 0xF have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| port | input | 4 | Port select |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte (combinational) |
| step_en | input | 1 | Transfer engine finished one unit |
| step_ch | input | 2 | Channel of the step |
| tc | output | 1 | Terminal count on this step |
| chan_mask | output | 4 | Mask bit for each channel |
| chan_mode | output | 16 | Mode nibble for each channel |

## Verification
The bench sweeps every channel and both registers with several value patterns and reads each byte back. This exposes swapped bytes, a pointer that skips reads, and cross-channel writes. It steps a channel through its full count with autoinitialize off and on. A wrong terminal-count compare would raise tc one step early or late, and a missing reload would leave the count at 0xFFFF. It checks that the pointer clear and master clear act mid-sequence, where a design that kept the pointer high would corrupt the next low-byte write. It also checks that unused ports leave the pointer and masks untouched, and that a combined read and write counts only as a write.

// File: rtl/xfer_regs_pkg.sv
package xfer_regs_pkg;
    localparam int CH_N  = 4;
    localparam int CH_W  = $clog2(CH_N);
    localparam int VAL_W = 16;
    localparam int BYTE_W = 8;
    localparam int MODE_W = 4;

    typedef enum logic [1:0] {
        KIND_DEMAND  = 2'd0,
        KIND_SINGLE  = 2'd1,
        KIND_BLOCK   = 2'd2,
        KIND_CASCADE = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        logic       autoinit;
        xfer_kind_e kind;
        logic       to_io;
    } chan_mode_t;

    localparam logic [3:0] P_MASK1   = 4'h8;
    localparam logic [3:0] P_MODE    = 4'h9;
    localparam logic [3:0] P_PTRCLR  = 4'hA;
    localparam logic [3:0] P_MCLR    = 4'hB;
    localparam logic [3:0] P_MASKCLR = 4'hC;
    localparam logic [3:0] P_MASKALL = 4'hD;

    function automatic logic [VAL_W-1:0] put_byte(input logic [VAL_W-1:0] v,
                                                  input logic hi,
                                                  input logic [BYTE_W-1:0] b);
        return hi ? {b, v[BYTE_W-1:0]} : {v[VAL_W-1:BYTE_W], b};
    endfunction

    function automatic logic [BYTE_W-1:0] get_byte(input logic [VAL_W-1:0] v,
                                                   input logic hi);
        return hi ? v[VAL_W-1:BYTE_W] : v[BYTE_W-1:0];
    endfunction
endpackage

// File: rtl/xfer_byte_ptr.sv
module xfer_byte_ptr (
    input  logic clk,
    input  logic rst,
    input  logic toggle,
    input  logic clear,
    output logic hi
);
    always_ff @(posedge clk) begin
        if (rst || clear) hi <= 1'b0;
        else if (toggle)  hi <= ~hi;
    end

    // R1
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (toggle && !clear) |=> (hi != $past(hi)));
    // R2
    ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> !hi);
endmodule

// File: rtl/xfer_mask_unit.sv
module xfer_mask_unit import xfer_regs_pkg::*; (
    input  logic            clk,
    input  logic            rst,
    input  logic            mclr,
    input  logic            single_we,
    input  logic            clr_all,
    input  logic            wr_all,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CH_N-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst || mclr)    mask <= '1;
        else if (clr_all)   mask <= '0;
        else if (wr_all)    mask <= wdata[CH_N-1:0];
        else if (single_we) mask[wdata[CH_W-1:0]] <= wdata[2];
    end

    // R9
    mclr_masks_chk: assert property (@(posedge clk) disable iff (rst)
        mclr |=> (mask == '1));
    // R7
    clr_all_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_all && !mclr) |=> (mask == '0));
    // R6
    single_only_chk: assert property (@(posedge clk) disable iff (rst)
        (single_we && !mclr && !clr_all && !wr_all) |=>
        ($countones(mask ^ $past(mask)) <= 1));
endmodule

// File: rtl/xfer_chan_slot.sv
module xfer_chan_slot import xfer_regs_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              mclr,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              mode_we,
    input  chan_mode_t        mode_in,
    input  logic              step,
    output logic [VAL_W-1:0]  cur_addr,
    output logic [VAL_W-1:0]  cur_cnt,
    output chan_mode_t        mode,
    output logic              at_tc
);
    logic [VAL_W-1:0] base_addr, base_cnt;
    logic             reload;

    assign at_tc  = (cur_cnt == '0);
    assign reload = step && at_tc && mode.autoinit;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            mode      <= '0;
        end else begin
            if (mclr)         mode <= '0;
            else if (mode_we) mode <= mode_in;

            if (wr_addr) begin
                base_addr <= put_byte(base_addr, hi, wdata);
                cur_addr  <= put_byte(cur_addr, hi, wdata);
            end else if (reload) begin
                cur_addr <= base_addr;
            end else if (step) begin
                cur_addr <= cur_addr + 1'b1;
            end

            if (wr_cnt) begin
                base_cnt <= put_byte(base_cnt, hi, wdata);
                cur_cnt  <= put_byte(cur_cnt, hi, wdata);
            end else if (reload) begin
                cur_cnt <= base_cnt;
            end else if (step) begin
                cur_cnt <= cur_cnt - 1'b1;
            end
        end
    end

    // R4
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !at_tc && !wr_cnt) |=> (cur_cnt == $past(cur_cnt) - 1'b1));
    // R5
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (step && at_tc && mode.autoinit && !wr_cnt && !wr_addr) |=>
        (cur_cnt == base_cnt && cur_addr == base_addr));
    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && at_tc && !mode.autoinit && !wr_cnt) |=> (cur_cnt == '1));
    // R9
    mclr_mode_chk: assert property (@(posedge clk) disable iff (rst)
        mclr |=> (mode == '0));
endmodule

// File: rtl/xfer_chan_regs.sv
module xfer_chan_regs import xfer_regs_pkg::*; (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [3:0]             port,
    input  logic [BYTE_W-1:0]      wdata,
    output logic [BYTE_W-1:0]      rdata,
    input  logic                   step_en,
    input  logic [CH_W-1:0]        step_ch,
    output logic                   tc,
    output logic [CH_N-1:0]        chan_mask,
    output logic [MODE_W*CH_N-1:0] chan_mode
);
    logic wr, rd, chan_port, hi, mclr;
    logic [VAL_W-1:0] cur_addr [CH_N];
    logic [VAL_W-1:0] cur_cnt  [CH_N];
    logic [CH_N-1:0]  at_tc;
    chan_mode_t       mode_in;

    assign wr        = wr_en;
    assign rd        = rd_en && !wr_en;
    assign chan_port = !port[3];
    assign mclr      = wr && (port == P_MCLR);
    assign mode_in   = chan_mode_t'(wdata[5:2]);

    xfer_byte_ptr u_ptr (
        .clk(clk), .rst(rst),
        .toggle((wr || rd) && chan_port),
        .clear(wr && (port == P_PTRCLR || port == P_MCLR)),
        .hi(hi)
    );

    xfer_mask_unit u_mask (
        .clk(clk), .rst(rst), .mclr(mclr),
        .single_we(wr && port == P_MASK1),
        .clr_all(wr && port == P_MASKCLR),
        .wr_all(wr && port == P_MASKALL),
        .wdata(wdata), .mask(chan_mask)
    );

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        logic       hit;
        chan_mode_t m;
        assign hit = wr && chan_port && (port[2:1] == CH_W'(c));
        xfer_chan_slot u_slot (
            .clk(clk), .rst(rst), .mclr(mclr),
            .wr_addr(hit && !port[0]),
            .wr_cnt(hit && port[0]),
            .hi(hi), .wdata(wdata),
            .mode_we(wr && port == P_MODE && wdata[CH_W-1:0] == CH_W'(c)),
            .mode_in(mode_in),
            .step(step_en && step_ch == CH_W'(c)),
            .cur_addr(cur_addr[c]), .cur_cnt(cur_cnt[c]),
            .mode(m), .at_tc(at_tc[c])
        );
        assign chan_mode[MODE_W*c +: MODE_W] = m;
    end

    assign tc = step_en && at_tc[step_ch];

    always_comb begin
        rdata = '0;
        if (rd && chan_port)
            rdata = get_byte(port[0] ? cur_cnt[port[2:1]] : cur_addr[port[2:1]], hi);
    end

    // R11
    always_comb begin
        if (!rst && !(rd_en && !wr_en && !port[3]))
            rdata_idle_chk: assert (rdata == '0);
    end
    // R4
    tc_only_on_step_chk: assert property (@(posedge clk) disable iff (rst)
        tc |-> step_en);
endmodule

// File: tb/xfer_chan_regs_test.sv
module xfer_chan_regs_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst, wr_en, rd_en, step_en;
    logic [3:0]  port;
    logic [7:0]  wdata, rdata;
    logic [1:0]  step_ch;
    logic        tc;
    logic [3:0]  chan_mask;
    logic [15:0] chan_mode;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_chan_regs uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port(port),
        .wdata(wdata), .rdata(rdata), .step_en(step_en), .step_ch(step_ch),
        .tc(tc), .chan_mask(chan_mask), .chan_mode(chan_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] p, input logic [7:0] d);
        @(negedge clk); wr_en = 1; port = p; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] p, output logic [7:0] v);
        @(negedge clk); rd_en = 1; port = p; #1 v = rdata;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic wr16(input logic [3:0] p, input logic [15:0] d);
        wr(4'hA, 8'h00); wr(p, d[7:0]); wr(p, d[15:8]);
    endtask

    task automatic rd16(input logic [3:0] p, output logic [15:0] v);
        logic [7:0] lo, hb;
        wr(4'hA, 8'h00); rd(p, lo); rd(p, hb); v = {hb, lo};
    endtask

    task automatic step(input logic [1:0] c, output logic t);
        @(negedge clk); step_en = 1; step_ch = c; #1 t = tc;
        @(negedge clk); step_en = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v, ea;
        logic [7:0]  b;
        logic        t;
        rst = 1; wr_en = 0; rd_en = 0; step_en = 0; step_ch = 0; port = 0; wdata = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R10 reset state
        chk("R10 mask", chan_mask, 4'hF);
        chk("R10 mode", chan_mode, 16'h0);
        rd16(4'h3, v); chk("R10 count", v, 16'h0);

        // R1 R3 sweep over channels, registers, patterns
        for (int k = 0; k < 3; k++) begin
            for (int c = 0; c < 4; c++) begin
                for (int r = 0; r < 2; r++) begin
                    logic [15:0] val = 16'(c * 16'h1111 + k * 16'h2F3D + r * 16'h0807);
                    wr16(4'(c*2 + r), val);
                end
            end
            for (int c = 0; c < 4; c++) begin
                for (int r = 0; r < 2; r++) begin
                    logic [15:0] val = 16'(c * 16'h1111 + k * 16'h2F3D + r * 16'h0807);
                    rd16(4'(c*2 + r), v);
                    chk("R1 R3 readback", v, val);
                end
            end
        end

        // R2 clear pointer mid-sequence: low byte written twice
        wr16(4'h4, 16'hAB12);
        wr(4'hA, 0); wr(4'h4, 8'h34); wr(4'hA, 0); wr(4'h4, 8'h56);
        rd16(4'h4, v); chk("R2 pointer clear", v, 16'hAB56);

        // R1 read toggles pointer: reads low then high without clear
        wr(4'hA, 0); rd(4'h4, b); chk("R1 read low", b, 8'h56);
        rd(4'h4, b); chk("R1 read high", b, 8'hAB);

        // R11 unused port write and read do not toggle pointer
        wr(4'hA, 0); wr(4'hE, 8'hFF); rd(4'hF, b); chk("R11 unused rdata", b, 8'h00);
        chk("R11 unused mask", chan_mask, 4'hF);
        rd(4'h4, b); chk("R11 pointer kept low", b, 8'h56);

        // R11 simultaneous read+write acts as write only
        wr(4'hA, 0);
        @(negedge clk); wr_en = 1; rd_en = 1; port = 4'h6; wdata = 8'h77; #1
        chk("R11 rdata during write", rdata, 8'h00);
        @(negedge clk); wr_en = 0; rd_en = 0;
        wr(4'h6, 8'h99);
        rd16(4'h6, v); chk("R11 write wins", v, 16'h9977);

        // R4 R5 no autoinit: count 2 -> tc on third step
        wr16(4'h2, 16'h10FE); wr16(4'h3, 16'h0002);
        for (int s = 1; s <= 4; s++) begin
            step(2'd1, t);
            chk(s == 3 ? "R4 tc on last step" : "R4 tc low", t, (s == 3) ? 1'b1 : 1'b0);
        end
        rd16(4'h3, v); chk("R5 count wraps", v, 16'hFFFE);
        rd16(4'h2, v); chk("R4 address advanced", v, 16'h1102);

        // R8 mode encoding and R5 autoinit reload
        wr(4'h9, {2'b00, 1'b1, 2'd2, 1'b1, 2'd1});
        chk("R8 mode ch1", chan_mode, 16'h00D0);
        wr16(4'h2, 16'h2000); wr16(4'h3, 16'h0001);
        step(2'd1, t); chk("R4 tc low autoinit", t, 1'b0);
        step(2'd1, t); chk("R5 tc autoinit", t, 1'b1);
        rd16(4'h3, v); chk("R5 count reload", v, 16'h0001);
        rd16(4'h2, v); chk("R5 address reload", v, 16'h2000);
        ea = 16'h2000;
        step(2'd1, t); rd16(4'h2, v); chk("R5 continues after reload", v, ea + 1);

        // R6 R7 masks
        wr(4'hC, 0); chk("R7 clear all", chan_mask, 4'h0);
        wr(4'h8, 8'h06); chk("R6 set ch2", chan_mask, 4'h4);
        wr(4'hD, 8'hFA); chk("R7 write all", chan_mask, 4'hA);
        wr(4'h8, 8'h03); chk("R6 clear ch3", chan_mask, 4'h2);
        wr(4'h8, 8'h04); chk("R6 set ch0", chan_mask, 4'h3);
        for (int c = 0; c < 4; c++) begin
            wr(4'h9, 8'(c) | 8'h3C);
        end
        chk("R8 all modes", chan_mode, 16'hFFFF);

        // R9 master clear with pointer left high
        wr16(4'h0, 16'hC0DE);
        wr(4'hA, 0); wr(4'h0, 8'h11);
        wr(4'hB, 0);
        chk("R9 masks set", chan_mask, 4'hF);
        chk("R9 modes cleared", chan_mode, 16'h0);
        wr(4'h0, 8'h22);
        rd16(4'h0, v); chk("R9 pointer low, value kept", v, 16'hC022);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule